// File: doc/BRIEF.md
# Single-Clock FIFO with Direction-Flag Status

This block is a first-in first-out buffer. Writes and reads run on one clock. A small register array holds the entries. Two cyclic pointer counters address the array, one for the write side and one for the read side. The two pointers hold the same value only when the buffer is completely empty or completely full. One flip-flop records whether the last change in occupancy went up or down, and that tells the two cases apart. No occupancy counter and no extra pointer bit are needed.

The pointer sequence is chosen by a parameter:

- plain binary count;
- reflected Gray code, where one bit changes per step;
- maximal-length LFSR.

The LFSR never visits the all-zero state, so an LFSR-addressed buffer holds one entry fewer than the array size. The address width sets the depth. The default is 4 entries, and the width may be raised to give up to 16 entries.

A producer raises the write enable with data. A consumer raises the read enable and takes the data one clock later. Full and Empty guard both sides: a write while Full and a read while Empty are dropped.

Top module: `dfifo`

## Requirements
- R1: While reset is asserted and on the first cycle after it, empty_o is 1 and full_o is 0.
- R2: Entries come out in the order they were written. rd_data_o shows the entry in the clock after an accepted read, that is, a read with rd_en_i=1 while empty_o=0.
- R3: With binary or Gray pointers, full_o becomes 1 after exactly 2^AW net accepted writes. It stays 0 while fewer are stored.
- R4: With LFSR pointers, full_o becomes 1 after exactly 2^AW-1 net accepted writes.
- R5: A write with wr_en_i=1 while full_o=1 is dropped. Its data never appears on rd_data_o, and the stored entries are not changed.
- R6: A read with rd_en_i=1 while empty_o=1 is dropped. The read pointer does not move, and the next written entry is the next one read.
- R7: If a read and a write are both accepted in one cycle, occupancy does not change, so full_o and empty_o keep their values. When full with both enables high, the read is taken and the write is dropped. When empty with both enables high, the write is taken and the read is dropped.
- R8: In Gray mode, each pointer changes at most one bit per clock.
- R9: rd_data_o holds its value in every cycle without an accepted read.
- R10: full_o and empty_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both sides |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DW | Data to store |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DW | Registered read data |
| full_o | output | 1 | No free entry |
| empty_o | output | 1 | No stored entry |

## Verification
Three instances, one per pointer kind, receive the same stimulus. Because their capacities differ (4, 4 and 3 at the default width), an off-by-one in the LFSR sequence or in the full compare shows up as a mismatch between instances.

- **Fill past capacity, then drain.** Separates dropped writes from stored ones and checks ordering.
- **Read on an empty buffer followed by a write.** Exposes a read pointer that moves when it should not.
- **Both enables high at mid occupancy, at full and at empty.** Checks that the direction flag holds and that each side is blocked correctly.
- **Long pseudo-random enable pattern.** Wraps the pointers many times and checks every word read against a reference queue.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;
  typedef enum logic [1:0] {
    PTR_BIN  = 2'd0,
    PTR_GRAY = 2'd1,
    PTR_LFSR = 2'd2
  } ptr_kind_e;

  function automatic int unsigned capacity(input int unsigned aw, input ptr_kind_e kind);
    return (kind == PTR_LFSR) ? (32'd1 << aw) - 1 : (32'd1 << aw);
  endfunction
endpackage

// File: rtl/dfifo_ptr.sv
module dfifo_ptr #(
  parameter int unsigned          AW   = 2,
  parameter dfifo_pkg::ptr_kind_e KIND = dfifo_pkg::PTR_BIN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o
);
  import dfifo_pkg::*;

  generate
    if (KIND == PTR_LFSR) begin : g_lfsr
      // taps AW, AW-1: maximal length for AW = 2..4
      localparam logic [AW-1:0] SEED = {{(AW-1){1'b0}}, 1'b1};
      logic [AW-1:0] st_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    st_q <= SEED;
        else if (adv_i) st_q <= {st_q[AW-2:0], st_q[AW-1] ^ st_q[AW-2]};
      end
      assign ptr_o = st_q;

      AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ptr_o != '0); // R4
    end else if (KIND == PTR_GRAY) begin : g_gray
      logic [AW-1:0] bin_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    bin_q <= '0;
        else if (adv_i) bin_q <= bin_q + 1'b1;
      end
      assign ptr_o = bin_q ^ (bin_q >> 1);

      AST_GRAY_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(ptr_o ^ $past(ptr_o)) <= 1); // R8
    end else begin : g_bin
      logic [AW-1:0] bin_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    bin_q <= '0;
        else if (adv_i) bin_q <= bin_q + 1'b1;
      end
      assign ptr_o = bin_q;
    end
  endgenerate

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_o)); // R6
endmodule

// File: rtl/dfifo_mem.sv
module dfifo_mem #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o)); // R9
endmodule

// File: rtl/dfifo_flags.sv
module dfifo_flags #(
  parameter int unsigned AW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] wptr_i,
  input  logic [AW-1:0] rptr_i,
  input  logic          wr_acc_i,
  input  logic          rd_acc_i,
  output logic          full_o,
  output logic          empty_o
);
  logic dir_q; // 1: last occupancy change was upward
  logic same;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    dir_q <= 1'b0;
    else if (wr_acc_i && !rd_acc_i) dir_q <= 1'b1;
    else if (rd_acc_i && !wr_acc_i) dir_q <= 1'b0;
  end

  assign same    = (wptr_i == rptr_i);
  assign full_o  = same &  dir_q;
  assign empty_o = same & ~dir_q;

  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o)); // R10
  AST_BOTH_KEEP_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc_i && rd_acc_i) |=> $stable(dir_q)); // R7
endmodule

// File: rtl/dfifo.sv
module dfifo #(
  parameter int unsigned          DW   = 8,
  parameter int unsigned          AW   = 2,
  parameter dfifo_pkg::ptr_kind_e KIND = dfifo_pkg::PTR_BIN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [AW-1:0] wptr, rptr;
  logic          wr_acc, rd_acc;

  assign wr_acc = wr_en_i & ~full_o;
  assign rd_acc = rd_en_i & ~empty_o;

  dfifo_ptr #(.AW(AW), .KIND(KIND)) u_wptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(wr_acc), .ptr_o(wptr)
  );

  dfifo_ptr #(.AW(AW), .KIND(KIND)) u_rptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(rd_acc), .ptr_o(rptr)
  );

  dfifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(wr_acc), .waddr_i(wptr), .wdata_i(wr_data_i),
    .re_i(rd_acc), .raddr_i(rptr), .rdata_o(rd_data_o)
  );

  dfifo_flags #(.AW(AW)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wptr_i(wptr), .rptr_i(rptr),
    .wr_acc_i(wr_acc), .rd_acc_i(rd_acc),
    .full_o(full_o), .empty_o(empty_o)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_en_i && !rd_en_i) |=> full_o); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_en_i && !wr_en_i) |=> empty_o); // R6
  AST_BOTH_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rd_en_i && !full_o && !empty_o) |=> (!full_o && !empty_o)); // R7
  AST_FULL_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_en_i && rd_en_i) |=> !full_o); // R7
  AST_EMPTY_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && wr_en_i && rd_en_i) |=> !empty_o); // R7
endmodule

// File: tb/dfifo_tb.sv
module dfifo_tb;
  import dfifo_pkg::*;

  localparam int DW = 8;
  localparam int AW = 2;
  localparam int NI = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;

  logic [DW-1:0] rdata [NI];
  logic          full  [NI];
  logic          empty [NI];

  always #10 clk = ~clk; // 50 MHz

  dfifo #(.DW(DW), .AW(AW), .KIND(PTR_BIN)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rdata[0]), .full_o(full[0]), .empty_o(empty[0]));
  dfifo #(.DW(DW), .AW(AW), .KIND(PTR_GRAY)) u_dut_gray (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rdata[1]), .full_o(full[1]), .empty_o(empty[1]));
  dfifo #(.DW(DW), .AW(AW), .KIND(PTR_LFSR)) u_dut_lfsr (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rdata[2]), .full_o(full[2]), .empty_o(empty[2]));

  // reference scoreboard: one circular queue of expected items per instance
  int            cap [NI] = '{4, 4, 3};
  int            cnt [NI];
  int            hd  [NI];
  logic [DW-1:0] mq  [NI][16];
  logic [DW-1:0] exp_rd [NI];

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int inst, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s inst%0d actual=%0h expected=%0h", req, what, inst, act, expv);
    end
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < NI; k++) begin
      chk(full[k] == (cnt[k] == cap[k]), req, "full", k, int'(full[k]), int'(cnt[k] == cap[k]));
      chk(empty[k] == (cnt[k] == 0), req, "empty", k, int'(empty[k]), int'(cnt[k] == 0));
      chk(rdata[k] == exp_rd[k], req, "rd_data", k, int'(rdata[k]), int'(exp_rd[k]));
    end
  endtask

  // driver: applies one cycle, updates reference, monitor checks after the edge
  task automatic cycle(input bit we, input bit re, input logic [DW-1:0] d, input string req);
    wr_en = we; rd_en = re; wr_data = d;
    for (int k = 0; k < NI; k++) begin
      bit wa, ra;
      int widx;
      wa = we && (cnt[k] < cap[k]);
      ra = re && (cnt[k] > 0);
      widx = (hd[k] + cnt[k]) % 16;
      if (ra) begin
        exp_rd[k] = mq[k][hd[k]];
        hd[k] = (hd[k] + 1) % 16;
      end
      if (wa) mq[k][widx] = d;
      cnt[k] = cnt[k] + int'(wa) - int'(ra);
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check_all(req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] seed;
    for (int k = 0; k < NI; k++) begin
      cnt[k] = 0; hd[k] = 0; exp_rd[k] = '0;
    end
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R6: read on empty, then write/read
    cycle(1'b0, 1'b1, 8'h00, "R6");
    cycle(1'b0, 1'b1, 8'h00, "R6");
    cycle(1'b1, 1'b0, 8'h5a, "R6");
    cycle(1'b0, 1'b1, 8'h00, "R6");

    // R3/R4/R5: fill past capacity
    for (int i = 0; i < 6; i++) cycle(1'b1, 1'b0, 8'h10 + 8'(i), (i < 3) ? "R4" : "R3");
    cycle(1'b1, 1'b0, 8'hee, "R5");
    // R2: drain in order
    for (int i = 0; i < 5; i++) cycle(1'b0, 1'b1, 8'h00, "R2");
    // R9: idle holds read data
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 8'h77, "R9");
    cycle(1'b1, 1'b0, 8'h33, "R9");
    cycle(1'b0, 1'b0, 8'h00, "R9");

    // R7: both at mid occupancy
    cycle(1'b1, 1'b0, 8'h21, "R7");
    for (int i = 0; i < 6; i++) cycle(1'b1, 1'b1, 8'h40 + 8'(i), "R7");
    // R7: both while full
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, 8'h60 + 8'(i), "R7");
    cycle(1'b1, 1'b1, 8'h99, "R7");
    for (int i = 0; i < 5; i++) cycle(1'b0, 1'b1, 8'h00, "R7");
    // R7: both while empty
    cycle(1'b1, 1'b1, 8'hab, "R7");
    cycle(1'b0, 1'b1, 8'h00, "R7");

    // R2/R8/R10: pseudo-random traffic, many pointer wraps
    seed = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      cycle(seed[20] | seed[21], seed[22] | (seed[23] & seed[24]), seed[31:24], "R2");
      for (int k = 0; k < NI; k++)
        chk(!(full[k] && empty[k]), "R10", "excl", k, int'(full[k]), 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule